// File: doc/BRIEF.md
# Whole-Packet Ring Buffer with Completion Descriptors

This block stores whole packets for one processing slot. Packet beats are written into a dual-port memory used as a circular ring, and once the final beat of a packet has landed, a 32-bit descriptor is queued in a small side FIFO. The descriptor carries a 16-bit start word address and a 16-bit byte length. A consumer therefore sees a descriptor only for a packet that is fully present. It then asks for that packet and receives exactly its beats, back to back.

Admission is decided on the first beat, from the byte length the writer declares with it. If the packet would not fit in the ring, or the descriptor FIFO has no room, or the stop input is high, the whole packet is discarded. The writer is never held back. An internal space tracker does three things:
- it counts the beats reserved by admitted packets;
- it holds the start address the next packet will use;
- it frees a packet's space only when the reader retires that packet.

The stop input lets a controller drain the slot: new packets are refused, stored ones can still be read, and the empty output reports when nothing is left.

Top module: `pkt_ring_buffer`

## Requirements
- R1: After reset, `empty` is 1 and `full`, `rd_desc_valid` and `rd_valid` are 0.
- R2: A packet is admitted only if all of the following hold on its first beat: its declared byte length L is non-zero, `stop_accept` is low, the descriptor FIFO is not full, and ceil(L/16) is no larger than the free beats. Otherwise the packet is dropped.
- R3: An admitted packet's descriptor becomes visible on `rd_desc_valid` only after its end beat. It appears in the cycle after that beat when the reader is idle. `rd_desc_len` equals L, and `rd_desc_start` equals the word address of its first beat.
- R4: After `rd_start` is accepted, ceil(L/16) beats appear on consecutive cycles, beginning two clock edges after the request. `rd_sop` marks the first beat, `rd_eop` marks the last, and the data equals what was written.
- R5: Word addresses wrap modulo the ring depth. Each admitted packet starts where the previous admitted packet ended, and a packet that crosses the top of the ring reads back intact.
- R6: A dropped packet leaves no descriptor, alters no stored data and does not move the next start address.
- R7: `full` is 1 exactly when reserved beats equal the ring depth.
- R8: A packet's space is returned only after its last beat has been delivered and its descriptor popped. `full` stays unchanged while that packet's beats are streaming.
- R9: While `stop_accept` is high, new packets are refused, but stored packets can still be read in full.
- R10: `empty` is 1 exactly when no beats are reserved, meaning no packet is stored or being written.
- R11: Descriptors are served in the order their packets completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_accept | input | 1 | Refuse packets whose first beat arrives while high |
| wr_valid | input | 1 | Write beat present |
| wr_sop | input | 1 | First beat of a packet |
| wr_eop | input | 1 | Last beat of a packet |
| wr_len | input | 16 | Packet byte length, sampled with the first beat |
| wr_data | input | DATA_W | Write beat data |
| rd_start | input | 1 | Request the packet at the descriptor head |
| rd_desc_valid | output | 1 | A complete packet is ready and the reader is idle |
| rd_desc_start | output | 16 | Start word address of the head packet |
| rd_desc_len | output | 16 | Byte length of the head packet |
| rd_valid | output | 1 | Read beat present |
| rd_sop | output | 1 | First beat of the packet being read |
| rd_eop | output | 1 | Last beat of the packet being read |
| rd_data | output | DATA_W | Read beat data |
| full | output | 1 | All ring beats reserved |
| empty | output | 1 | No beats reserved |

## Verification
The bench builds the block with a 128-bit data path, a 32-word ring and a 4-entry descriptor FIFO. With a ring that small, two 16-beat packets fill it, so `full`, the whole-packet drop on a full ring and streaming under `full` can all be reached with a few short packets. Packets of up to 13 beats from the random phase wrap the ring many times, and a fifth short packet hits the descriptor-FIFO limit. Reads interleaved with writes and the stop input exercise release ordering and address continuity across wraps.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

    typedef struct packed {
        logic [15:0] start;
        logic [15:0] len;
    } pkt_desc_t;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_KEEP,
        WR_DROP
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_STREAM,
        RD_RETIRE
    } rd_state_t;

    // beats needed to carry len bytes with 2**lg_bytes bytes per beat
    function automatic logic [16:0] beats_of(input logic [15:0] len, input int unsigned lg_bytes);
        logic [16:0] round;
        round = (17'd1 << lg_bytes) - 17'd1;
        return ({1'b0, len} + round) >> lg_bytes;
    endfunction

endpackage

// File: rtl/pktbuf_ram.sv
module pktbuf_ram #(
    parameter int DW = 128,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/pktbuf_desc_fifo.sv
module pktbuf_desc_fifo
    import pktbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  pkt_desc_t push_desc,
    input  logic      pop,
    output pkt_desc_t head,
    output logic      empty,
    output logic      full
);
    localparam int PW = $clog2(DEPTH);

    pkt_desc_t slots [DEPTH];
    logic [PW:0] wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[PW-1:0] == rp[PW-1:0]) && (wp[PW] != rp[PW]);
    assign head  = slots[rp[PW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) begin
                slots[wp[PW-1:0]] <= push_desc;
                wp <= wp + 1'b1;
            end
            if (pop) rp <= rp + 1'b1;
        end
    end

    // R11
    no_push_full_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R11
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/pktbuf_space.sv
module pktbuf_space #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reserve,
    input  logic [AW:0]   reserve_beats,
    input  logic          release_en,
    input  logic [AW:0]   release_beats,
    output logic [AW:0]   free_beats,
    output logic [AW-1:0] head_addr,
    output logic          full,
    output logic          empty
);
    localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

    logic [AW:0] used;

    assign free_beats = CAP - used;
    assign full       = (used == CAP);
    assign empty      = (used == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            used      <= '0;
            head_addr <= '0;
        end else begin
            used <= used + (reserve ? reserve_beats : '0) - (release_en ? release_beats : '0);
            if (reserve) head_addr <= head_addr + reserve_beats[AW-1:0];
        end
    end

    // R7
    used_within_cap_chk: assert property (@(posedge clk) disable iff (rst) used <= CAP);
    // R8
    release_covered_chk: assert property (@(posedge clk) disable iff (rst) release_en |-> used >= release_beats);
endmodule

// File: rtl/pkt_ring_buffer.sv
module pkt_ring_buffer
    import pktbuf_pkg::*;
#(
    parameter int DATA_W     = 128,
    parameter int DEPTH      = 512,
    parameter int DESC_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_accept,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [15:0]       wr_len,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_start,
    output logic              rd_desc_valid,
    output logic [15:0]       rd_desc_start,
    output logic [15:0]       rd_desc_len,
    output logic              rd_valid,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int LG_BYTES   = $clog2(BEAT_BYTES);
    localparam int AW         = $clog2(DEPTH);

    // ---------------- shared state ----------------
    logic [AW:0]   free_beats;
    logic [AW-1:0] head_addr;
    logic          reserve, release_en;
    logic [AW:0]   release_beats;
    logic          d_push, d_pop, d_empty, d_full;
    pkt_desc_t     d_head, d_in;
    logic          ram_we, ram_re;
    logic [AW-1:0] ram_waddr, ram_raddr;

    // ---------------- writer ----------------
    wr_state_t     wr_state;
    logic [AW-1:0] wr_base;
    logic [AW:0]   wr_beats_q, wr_idx;
    logic [15:0]   wr_len_q;

    logic          sop_beat, sop_ok, keep_beat;
    logic [16:0]   sop_beats;
    logic [AW:0]   cur_idx, cur_beats;
    logic [AW-1:0] cur_base;

    assign sop_beat  = wr_valid && wr_sop;
    assign sop_beats = beats_of(wr_len, LG_BYTES);
    assign sop_ok    = (wr_len != 16'd0) && !stop_accept && !d_full
                       && (sop_beats <= 17'(free_beats));
    assign keep_beat = wr_valid && (sop_beat ? sop_ok : (wr_state == WR_KEEP));
    assign cur_idx   = sop_beat ? '0 : wr_idx;
    assign cur_beats = sop_beat ? (AW+1)'(sop_beats) : wr_beats_q;
    assign cur_base  = sop_beat ? head_addr : wr_base;

    assign ram_we    = keep_beat && (cur_idx < cur_beats);
    assign ram_waddr = cur_base + cur_idx[AW-1:0];
    assign reserve   = sop_beat && sop_ok;
    assign d_push    = keep_beat && wr_eop;
    assign d_in.start = 16'(cur_base);
    assign d_in.len   = sop_beat ? wr_len : wr_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_state   <= WR_IDLE;
            wr_base    <= '0;
            wr_beats_q <= '0;
            wr_idx     <= '0;
            wr_len_q   <= '0;
        end else if (sop_beat) begin
            wr_base    <= head_addr;
            wr_beats_q <= (AW+1)'(sop_beats);
            wr_len_q   <= wr_len;
            wr_idx     <= (AW+1)'(1);
            if (wr_eop)      wr_state <= WR_IDLE;
            else if (sop_ok) wr_state <= WR_KEEP;
            else             wr_state <= WR_DROP;
        end else if (wr_valid && wr_state != WR_IDLE) begin
            if (wr_idx < wr_beats_q) wr_idx <= wr_idx + 1'b1;
            if (wr_eop) wr_state <= WR_IDLE;
        end
    end

    // ---------------- reader ----------------
    rd_state_t     rd_state;
    logic [AW-1:0] rd_base;
    logic [AW:0]   rd_beats, rd_idx;
    logic          rd_last;

    assign rd_desc_valid = !d_empty && (rd_state == RD_IDLE);
    assign rd_desc_start = d_head.start;
    assign rd_desc_len   = d_head.len;
    assign rd_last       = (rd_idx == rd_beats - 1'b1);
    assign ram_re        = (rd_state == RD_STREAM);
    assign ram_raddr     = rd_base + rd_idx[AW-1:0];
    assign d_pop         = (rd_state == RD_RETIRE);
    assign release_en    = d_pop;
    assign release_beats = rd_beats;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_state <= RD_IDLE;
            rd_base  <= '0;
            rd_beats <= '0;
            rd_idx   <= '0;
            rd_valid <= 1'b0;
            rd_sop   <= 1'b0;
            rd_eop   <= 1'b0;
        end else begin
            unique case (rd_state)
                RD_IDLE: begin
                    rd_valid <= 1'b0;
                    rd_sop   <= 1'b0;
                    rd_eop   <= 1'b0;
                    if (rd_start && rd_desc_valid) begin
                        rd_base  <= AW'(d_head.start);
                        rd_beats <= (AW+1)'(beats_of(d_head.len, LG_BYTES));
                        rd_idx   <= '0;
                        rd_state <= RD_STREAM;
                    end
                end
                RD_STREAM: begin
                    rd_valid <= 1'b1;
                    rd_sop   <= (rd_idx == '0);
                    rd_eop   <= rd_last;
                    rd_idx   <= rd_idx + 1'b1;
                    if (rd_last) rd_state <= RD_RETIRE;
                end
                default: begin
                    rd_valid <= 1'b0;
                    rd_sop   <= 1'b0;
                    rd_eop   <= 1'b0;
                    rd_state <= RD_IDLE;
                end
            endcase
        end
    end

    // ---------------- instances ----------------
    pktbuf_ram #(.DW(DATA_W), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_data),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (rd_data)
    );

    pktbuf_desc_fifo #(.DEPTH(DESC_DEPTH)) u_desc (
        .clk       (clk),
        .rst       (rst),
        .push      (d_push),
        .push_desc (d_in),
        .pop       (d_pop),
        .head      (d_head),
        .empty     (d_empty),
        .full      (d_full)
    );

    pktbuf_space #(.AW(AW)) u_space (
        .clk           (clk),
        .rst           (rst),
        .reserve       (reserve),
        .reserve_beats ((AW+1)'(sop_beats)),
        .release_en    (release_en),
        .release_beats (release_beats),
        .free_beats    (free_beats),
        .head_addr     (head_addr),
        .full          (full),
        .empty         (empty)
    );

    // R4
    beat_run_chk: assert property (@(posedge clk) disable iff (rst) (rd_valid && !rd_eop) |=> rd_valid);
    // R4
    eop_has_valid_chk: assert property (@(posedge clk) disable iff (rst) (rd_sop || rd_eop) |-> rd_valid);
    // R10
    desc_not_empty_chk: assert property (@(posedge clk) disable iff (rst) rd_desc_valid |-> !empty);
    // R3
    desc_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(d_empty) |-> $past(wr_valid && wr_eop));
    // R9
    stop_keeps_head_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sop && stop_accept) |=> $stable(head_addr));
endmodule

// File: tb/pkt_ring_buffer_test.sv
module pkt_ring_buffer_test;
    localparam int DW  = 128;
    localparam int DEP = 32;
    localparam int DD  = 4;
    localparam int BB  = DW / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stop_accept = 1'b0;
    logic          wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic [15:0]   wr_len = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_start = 1'b0;
    logic          rd_desc_valid, rd_valid, rd_sop, rd_eop, full, empty;
    logic [15:0]   rd_desc_start, rd_desc_len;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int m_used = 0;
    int m_head = 0;
    int next_id = 1;
    int q_start[$];
    int q_len[$];
    int q_id[$];

    always #5 clk = ~clk;

    pkt_ring_buffer #(.DATA_W(DW), .DEPTH(DEP), .DESC_DEPTH(DD)) uut (
        .clk(clk), .rst(rst), .stop_accept(stop_accept),
        .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .wr_len(wr_len), .wr_data(wr_data), .rd_start(rd_start),
        .rd_desc_valid(rd_desc_valid), .rd_desc_start(rd_desc_start),
        .rd_desc_len(rd_desc_len), .rd_valid(rd_valid), .rd_sop(rd_sop),
        .rd_eop(rd_eop), .rd_data(rd_data), .full(full), .empty(empty)
    );

    function automatic int nbeats(int len);
        return (len == 0) ? 1 : (len + BB - 1) / BB;
    endfunction

    function automatic logic [DW-1:0] beat_data(int id, int b);
        logic [31:0] a;
        a = 32'(id) * 32'h9E37_79B1 + 32'(b);
        return {a, ~a, 32'(id), 32'(b) ^ 32'h5A5A_0000};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_levels(input string req);
        chk(full == (m_used == DEP), {req, " R7 full"}, DW'(full), DW'(m_used == DEP));
        chk(empty == (m_used == 0), {req, " R10 empty"}, DW'(empty), DW'(m_used == 0));
    endtask

    // R2 admission model; R5 start continuity; R6 drops leave model unchanged
    task automatic send_pkt(input int len, input bit stop, input bit watch_desc);
        int nb;
        int id;
        bit acc;
        nb  = nbeats(len);
        id  = next_id++;
        acc = (len != 0) && !stop && (q_len.size() < DD) && (nb <= DEP - m_used);
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            if (watch_desc) chk(rd_desc_valid == 1'b0, "R3 no descriptor before end beat", DW'(rd_desc_valid), '0);
            wr_valid = 1'b1;
            wr_sop = (b == 0);
            wr_eop = (b == nb - 1);
            wr_len = 16'(len);
            wr_data = beat_data(id, b);
            stop_accept = stop;
        end
        @(negedge clk);
        wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; stop_accept = 1'b0;
        if (watch_desc) chk(rd_desc_valid == 1'b1, "R3 descriptor after end beat", DW'(rd_desc_valid), 1);
        if (acc) begin
            q_start.push_back(m_head);
            q_len.push_back(len);
            q_id.push_back(id);
            m_head = (m_head + nb) % DEP;
            m_used += nb;
        end
    endtask

    // R4 beat stream; R11 order; R8 release timing
    task automatic read_pkt(input bit full_during);
        int nb;
        int id;
        @(negedge clk);
        if (q_len.size() == 0) begin
            chk(rd_desc_valid == 1'b0, "R6 no descriptor expected", DW'(rd_desc_valid), '0);
            return;
        end
        nb = nbeats(q_len[0]);
        id = q_id[0];
        chk(rd_desc_valid == 1'b1, "R3 descriptor present", DW'(rd_desc_valid), 1);
        chk(rd_desc_start == 16'(q_start[0]), "R5 R11 descriptor start", DW'(rd_desc_start), DW'(q_start[0]));
        chk(rd_desc_len == 16'(q_len[0]), "R3 R11 descriptor length", DW'(rd_desc_len), DW'(q_len[0]));
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            chk(rd_valid && (rd_sop == (b == 0)) && (rd_eop == (b == nb - 1)), "R4 beat framing",
                DW'({rd_valid, rd_sop, rd_eop}), DW'({1'b1, b == 0, b == nb - 1}));
            chk(rd_data == beat_data(id, b), "R4 R5 beat data", rd_data, beat_data(id, b));
            if (full_during) chk(full == 1'b1, "R8 full held while streaming", DW'(full), 1);
        end
        void'(q_start.pop_front());
        void'(q_len.pop_front());
        void'(q_id.pop_front());
        m_used -= nb;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R4 stream ends", DW'(rd_valid), '0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4096);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(empty && !full && !rd_desc_valid && !rd_valid, "R1 reset state",
            DW'({empty, full, rd_desc_valid, rd_valid}), DW'(4'b1000));

        // R3 directed: descriptor only after end beat
        send_pkt(40, 1'b0, 1'b1);
        chk_levels("R3");
        read_pkt(1'b0);
        chk_levels("R10 drained");

        // R9 R6: refused packet, head unchanged for next one
        send_pkt(20, 1'b1, 1'b0);
        @(negedge clk);
        chk(rd_desc_valid == 1'b0, "R9 R6 refused under stop", DW'(rd_desc_valid), '0);
        chk(empty == 1'b1, "R6 nothing reserved", DW'(empty), 1);
        send_pkt(0, 1'b0, 1'b0);
        @(negedge clk);
        chk(rd_desc_valid == 1'b0, "R2 zero length dropped", DW'(rd_desc_valid), '0);
        send_pkt(33, 1'b0, 1'b0);
        stop_accept = 1'b1;
        read_pkt(1'b0);
        stop_accept = 1'b0;

        // R7 R8 R5: fill to full across the wrap point
        send_pkt(256, 1'b0, 1'b0);
        send_pkt(250, 1'b0, 1'b0);
        @(negedge clk);
        chk_levels("R7 filled");
        send_pkt(1, 1'b0, 1'b0);
        chk_levels("R2 full drop");
        read_pkt(1'b1);
        chk_levels("R8 released");
        read_pkt(1'b0);

        // R11 R2: descriptor FIFO limit
        for (int i = 0; i < DD + 1; i++) send_pkt(8 + i, 1'b0, 1'b0);
        for (int i = 0; i < DD + 1; i++) read_pkt(1'b0);
        chk_levels("R11 drained");

        // random mix
        for (int it = 0; it < 120; it++) begin
            if ($urandom % 3 < 2) send_pkt(int'($urandom % 200), ($urandom % 8) == 0, 1'b0);
            else read_pkt(1'b0);
            @(negedge clk);
            chk_levels("R2 random");
        end
        while (q_len.size() > 0) read_pkt(1'b0);
        @(negedge clk);
        chk_levels("R10 final");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule